// File: doc/BRIEF.md
# Instruction-Cycle Tick Divider

This block makes periodic enable pulses from the oscillator clock for a small controller core. A phase counter first marks one instruction cycle every six oscillator clocks with a single-clock pulse. A ripple counter then counts those instruction pulses, and a 4-bit option code picks a power-of-two division ratio from 1/2 to 1/4096. The divided pulse is shared. The timer uses it as its count enable, the serial port uses it as its internal shift enable, and a toggle flop turns it into a square wave for a clock-output pin.

Every output is an enable that lasts one oscillator clock, or a registered level. The block gates no clock. Reset clears the phase counter, the ripple counter and the toggle flop together, so the position of every pulse after reset is fixed. The option code is meant to be static. It is normally set while the block is held in reset.

Top module: `instr_tick_divider`

## Requirements
- R1: While `rstN` is low, and in the first clock after it rises, `instrTick`, `divTick` and `clkOut` are all 0.
- R2: `instrTick` is high for exactly one clock in every six. The first pulse appears in the sixth clock after reset release, that is after five rising edges with reset inactive.
- R3: Option codes 1 through 12 (hex 1..c) select exponent k equal to the code. `divTick` then repeats every 6·2^k clocks.
- R4: `divTick` is never high unless `instrTick` is high in the same clock.
- R5: Option codes 0 and 13..15 (hex 0, d, e, f) behave exactly like code 1, giving a ratio of 1/2.
- R6: `clkOut` inverts on the rising edge that ends each `divTick` clock and holds at all other edges. This gives a 50% duty wave at half the `divTick` rate.
- R7: After reset, the first `divTick` coincides with instruction pulse number 2^k, counting from 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selCode | input | 4 | Division option code |
| instrTick | output | 1 | One-clock pulse per instruction cycle |
| divTick | output | 1 | One-clock pulse at the selected divided rate |
| clkOut | output | 1 | Square wave that toggles on each divided pulse |

## Verification
A fault in the phase counter shifts or spreads `instrTick` within the first six clocks after reset, and every later pulse moves with it. A stuck or miscounting ripple-counter bit, or a wrong code decode, shows as a `divTick` that is early, late or missing, at the first expected divided pulse (instruction pulse 2^k). That takes up to 24,576 clocks for the slowest ratio. A broken toggle flop shows at `clkOut` one clock after the first `divTick`. For these reasons the bench compares all three outputs every clock against a cycle-count model and runs the slowest ratio for two full periods.

// File: rtl/tick_div_pkg.sv
package tick_div_pkg;
  localparam int EXP_W = 4;

  typedef struct packed {
    logic             cycleTick;
    logic [EXP_W-1:0] divExp;
  } ctlStrobes_t;
endpackage

// File: rtl/tick_div_ctl.sv
module tick_div_ctl
  import tick_div_pkg::*;
#(
  parameter int PHASE_LEN = 6,
  parameter int CODE_W    = 4,
  parameter int CNT_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] selCode,
  output ctlStrobes_t       strobes
);
  localparam int PH_W = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASE_LEN - 1);

  logic [PH_W-1:0]  phase;
  logic             cycleEnd;
  logic [EXP_W-1:0] expDecoded;

  assign cycleEnd = (phase == PH_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (cycleEnd) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // Legal codes map straight to the exponent; all others fall back to 1.
  always_comb begin
    if ((int'(selCode) >= 1) && (int'(selCode) <= CNT_W)) begin
      expDecoded = EXP_W'(selCode);
    end else begin
      expDecoded = EXP_W'(1);
    end
  end

  assign strobes.cycleTick = cycleEnd;
  assign strobes.divExp    = expDecoded;

  // R2
  single_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cycleTick |=> !strobes.cycleTick);

  // R5
  exp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.divExp >= EXP_W'(1)) && (int'(strobes.divExp) <= CNT_W));
endmodule

// File: rtl/tick_div_dp.sv
module tick_div_dp
  import tick_div_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  output logic        divTick,
  output logic        clkOut
);
  logic [CNT_W-1:0] rippleCnt;
  logic [CNT_W:0]   wrapHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rippleCnt <= '0;
    end else if (strobes.cycleTick) begin
      rippleCnt <= rippleCnt + 1'b1;
    end
  end

  assign wrapHit[0] = 1'b1;
  for (genvar k = 1; k <= CNT_W; k++) begin : g_wrap
    assign wrapHit[k] = &rippleCnt[k-1:0];
  end

  assign divTick = strobes.cycleTick & wrapHit[strobes.divExp];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkOut <= 1'b0;
    end else if (divTick) begin
      clkOut <= ~clkOut;
    end
  end

  // R4
  div_in_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    divTick |-> strobes.cycleTick);

  // R6
  toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    divTick |=> (clkOut != $past(clkOut)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !divTick |=> $stable(clkOut));

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    divTick |=> (rippleCnt[0] == 1'b0));
endmodule

// File: rtl/instr_tick_divider.sv
module instr_tick_divider
  import tick_div_pkg::*;
#(
  parameter int PHASE_LEN = 6,
  parameter int CODE_W    = 4,
  parameter int CNT_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] selCode,
  output logic              instrTick,
  output logic              divTick,
  output logic              clkOut
);
  ctlStrobes_t strobes;

  tick_div_ctl #(
    .PHASE_LEN(PHASE_LEN),
    .CODE_W   (CODE_W),
    .CNT_W    (CNT_W)
  ) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .selCode(selCode),
    .strobes(strobes)
  );

  tick_div_dp #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .divTick(divTick),
    .clkOut (clkOut)
  );

  assign instrTick = strobes.cycleTick;
endmodule

// File: tb/tb_instr_tick_divider.sv
module tb_instr_tick_divider;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] selCode = 4'd1;
  logic instrTick, divTick, clkOut;
  int total = 0;
  int bad = 0;
  bit timedOut = 1'b0;

  always #5 clk = ~clk;

  instr_tick_divider dut (
    .clk(clk), .rstN(rstN), .selCode(selCode),
    .instrTick(instrTick), .divTick(divTick), .clkOut(clkOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Resets with the given code, then compares every clock against the model.
  task automatic runCode(input logic [3:0] code, input int k, input int cycles, input string req);
    int expTick, expDiv, expOut, m, tickErr, divErr, outErr, firstDiv;
    rstN = 1'b0;
    selCode = code;
    repeat (3) @(negedge clk);
    // R1: held in reset
    check("R1", "instrTick in reset", int'(instrTick), 0);
    check("R1", "divTick in reset", int'(divTick), 0);
    check("R1", "clkOut in reset", int'(clkOut), 0);
    rstN = 1'b1;
    #1;
    expOut = 0; tickErr = 0; divErr = 0; outErr = 0; firstDiv = -1;
    for (int i = 0; i < cycles; i++) begin
      if (i > 0) begin
        @(negedge clk);
        #1;
      end
      expTick = ((i % 6) == 5) ? 1 : 0;
      m = i / 6;
      expDiv = (expTick == 1 && (((m + 1) % (1 << k)) == 0)) ? 1 : 0;
      if (i == 0) begin
        // R1: first clock after release
        check("R1", "outputs after release", int'({instrTick, divTick, clkOut}), 0);
      end
      if (int'(instrTick) != expTick) begin
        if (tickErr == 0) check("R2", $sformatf("instrTick at clock %0d", i), int'(instrTick), expTick);
        tickErr++;
      end
      if (int'(divTick) != expDiv) begin
        if (divErr == 0) check(req, $sformatf("divTick at clock %0d", i), int'(divTick), expDiv);
        divErr++;
      end
      if (int'(clkOut) != expOut) begin
        if (outErr == 0) check("R6", $sformatf("clkOut at clock %0d", i), int'(clkOut), expOut);
        outErr++;
      end
      if (divTick && !instrTick) begin
        check("R4", "divTick without instrTick", 1, 0);
      end
      if (divTick && firstDiv < 0) firstDiv = i;
      if (expDiv == 1) expOut = 1 - expOut;
    end
    if (tickErr == 0) check("R2", "instrTick every six clocks", 0, 0);
    if (divErr == 0) check(req, $sformatf("divTick period for code %0d", code), 0, 0);
    if (outErr == 0) check("R6", "clkOut toggle pattern", 0, 0);
    // R7: first divided pulse lands on instruction pulse 2^k
    check("R7", "first divTick clock", firstDiv, 6 * (1 << k) - 1);
  endtask

  task automatic testBasicRatio();
    runCode(4'h1, 1, 200, "R3");
  endtask

  task automatic testMidRatios();
    runCode(4'h3, 3, 300, "R3");
    runCode(4'h5, 5, 900, "R3");
    runCode(4'h9, 9, 7000, "R3");
  endtask

  task automatic testSlowest();
    runCode(4'hc, 12, 2 * 6 * 4096 + 20, "R3");
  endtask

  task automatic testIllegalCodes();
    runCode(4'h0, 1, 120, "R5");
    runCode(4'hd, 1, 120, "R5");
    runCode(4'hf, 1, 120, "R5");
  endtask

  initial begin
    #2000000;
    timedOut = 1'b1;
  end

  initial begin
    fork
      begin
        testBasicRatio();
        testMidRatios();
        testSlowest();
        testIllegalCodes();
      end
      begin
        wait (timedOut);
        check("R2", "watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule